// File: doc/BRIEF.md
# Interrupt Gate Privilege Checker

This block judges one interrupt or exception dispatch at a time. A request carries the event vector, a flag saying the event came from a software interrupt instruction, the code segment selector of the interrupted flow, the type nibble and privilege level of the gate descriptor selected by the vector, the privilege level of the handler's code segment descriptor, and the event class. The class is one of fault, trap or abort.

One cycle later the block returns a registered verdict. The verdict is either a general-protection fault request or a dispatch decision. A dispatch decision says whether maskable interrupts are disabled on entry, whether the stack must be switched, whether a hardware error code is pushed, whether the saved return address is the next instruction, and whether the gate is a task gate.

The descriptor table memory, segment loading and the stack push sequence sit around this block and are handled elsewhere.

Top module: `gate_priv_checker`

## Requirements
- R1: The current privilege level (CPL) is bits [1:0] of `cs_sel`. No other selector bit affects any output.
- R2: A request whose CPL is numerically smaller than `seg_dpl` produces `gp_fault`=1.
- R3: When `soft_evt`=1, a request whose `gate_dpl` is numerically smaller than the CPL produces `gp_fault`=1. When `soft_evt`=0 this gate comparison is skipped.
- R4: Gate types 4'hE and 4'h6 are interrupt gates and give `clr_if`=1. Gate types 4'hF and 4'h7 are trap gates and give `clr_if`=0.
- R5: Gate type 4'h5 is a task gate. It gives `task_gate`=1 and `clr_if`=0. Any type other than 4'h5, 4'h6, 4'h7, 4'hE and 4'hF gives `gp_fault`=1.
- R6: On a dispatch without a fault, `stk_switch`=1 exactly when the CPL differs from `seg_dpl`.
- R7: The event class is encoded as fault 2'b00, trap 2'b01 and abort 2'b10. `ret_next`=1 only for a trap. A fault or an abort gives 0, meaning the saved address is the current instruction.
- R8: `err_push`=1 exactly for vectors 8, 10, 11, 12, 13, 14 and 17 when `soft_evt`=0. It is 0 for every other vector and for every software event.
- R9: Outputs are registered. `dec_valid` pulses for one cycle, in the cycle after a cycle with `req_valid`=1, and is 0 otherwise. After reset every output is 0.
- R10: When `gp_fault`=1, the outputs `clr_if`, `stk_switch`, `err_push`, `ret_next` and `task_gate` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A dispatch request is present this cycle |
| vector | input | 8 | Event vector, 0 to 255 |
| soft_evt | input | 1 | Event raised by a software interrupt instruction |
| cs_sel | input | 16 | Code segment selector of the interrupted flow |
| gate_type | input | 4 | Type nibble of the gate descriptor |
| gate_dpl | input | 2 | Privilege level of the gate descriptor |
| seg_dpl | input | 2 | Privilege level of the handler segment descriptor |
| evt_class | input | 2 | 00 fault, 01 trap, 10 abort |
| dec_valid | output | 1 | Verdict valid pulse |
| gp_fault | output | 1 | General-protection fault requested |
| clr_if | output | 1 | Disable maskable interrupts on entry |
| stk_switch | output | 1 | Switch to the stack of the new privilege level |
| err_push | output | 1 | Push a hardware error code |
| ret_next | output | 1 | Saved return address is the next instruction |
| task_gate | output | 1 | Dispatch goes through a task gate |

## Verification
Several properties are checked on every cycle after a request:
- the two privilege comparisons, and that the hardware-interrupt path never raises the gate comparison;
- the stack-switch relation;
- the zeroing of decision outputs under a fault;
- the single-cycle valid pulse;
- that a task gate never disables interrupts.

Other behaviour only shows up in the bench's directed scenarios. These include the gate-type decoding of every legal and illegal nibble, the exact set of vectors that push an error code, the return-address choice per class, and the insensitivity to upper selector bits.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
    typedef enum logic [1:0] {
        EVT_FAULT = 2'b00,
        EVT_TRAP  = 2'b01,
        EVT_ABORT = 2'b10
    } evt_class_e;

    typedef enum logic [1:0] {
        GK_INTR,
        GK_TRAP,
        GK_TASK,
        GK_BAD
    } gate_kind_e;

    typedef struct packed {
        logic valid;
        logic gp;
        logic clr_if;
        logic stk_sw;
        logic err_push;
        logic ret_next;
        logic task_gate;
    } decision_t;
endpackage

// File: rtl/gpc_type_decode.sv
module gpc_type_decode
    import gpc_pkg::*;
#(
    parameter int TYPE_W = 4
) (
    input  logic [TYPE_W-1:0] gate_type,
    output gate_kind_e        kind
);
    always_comb begin
        unique case (gate_type)
            TYPE_W'(4'hE), TYPE_W'(4'h6): kind = GK_INTR;
            TYPE_W'(4'hF), TYPE_W'(4'h7): kind = GK_TRAP;
            TYPE_W'(4'h5):                kind = GK_TASK;
            default:                      kind = GK_BAD;
        endcase
    end
endmodule

// File: rtl/gpc_priv_compare.sv
module gpc_priv_compare #(
    parameter int PL_W = 2
) (
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] gate_dpl,
    input  logic [PL_W-1:0] seg_dpl,
    input  logic            soft_evt,
    output logic            seg_viol,
    output logic            gate_viol,
    output logic            ring_change
);
    // Handler segment may not be less privileged than the caller.
    assign seg_viol    = (cpl < seg_dpl);
    // Gate check applies only to software-raised events.
    assign gate_viol   = soft_evt && (gate_dpl < cpl);
    assign ring_change = (cpl != seg_dpl);
endmodule

// File: rtl/gpc_errcode_lookup.sv
module gpc_errcode_lookup #(
    parameter int          VEC_W    = 8,
    parameter int          LOW_VECS = 32,
    parameter logic [31:0] ERR_MASK = 32'h0002_7D00
) (
    input  logic [VEC_W-1:0] vector,
    input  logic             soft_evt,
    output logic             err_push
);
    logic [LOW_VECS-1:0] hit;

    for (genvar i = 0; i < LOW_VECS; i++) begin : g_vec
        assign hit[i] = ERR_MASK[i] && (vector == VEC_W'(i));
    end

    assign err_push = !soft_evt && (|hit);
endmodule

// File: rtl/gate_priv_checker.sv
module gate_priv_checker
    import gpc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int SEL_W  = 16,
    parameter int PL_W   = 2,
    parameter int TYPE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  vector,
    input  logic              soft_evt,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic [TYPE_W-1:0] gate_type,
    input  logic [PL_W-1:0]   gate_dpl,
    input  logic [PL_W-1:0]   seg_dpl,
    input  logic [1:0]        evt_class,
    output logic              dec_valid,
    output logic              gp_fault,
    output logic              clr_if,
    output logic              stk_switch,
    output logic              err_push,
    output logic              ret_next,
    output logic              task_gate
);
    localparam int CPL_LSB = 0;

    logic [PL_W-1:0] cpl;
    gate_kind_e      kind;
    logic            seg_viol, gate_viol, ring_change, err_hit;
    decision_t       dec_d, dec_q;

    assign cpl = cs_sel[CPL_LSB +: PL_W];

    gpc_type_decode #(.TYPE_W(TYPE_W)) u_type (
        .gate_type (gate_type),
        .kind      (kind)
    );

    gpc_priv_compare #(.PL_W(PL_W)) u_priv (
        .cpl         (cpl),
        .gate_dpl    (gate_dpl),
        .seg_dpl     (seg_dpl),
        .soft_evt    (soft_evt),
        .seg_viol    (seg_viol),
        .gate_viol   (gate_viol),
        .ring_change (ring_change)
    );

    gpc_errcode_lookup #(.VEC_W(VEC_W)) u_err (
        .vector   (vector),
        .soft_evt (soft_evt),
        .err_push (err_hit)
    );

    always_comb begin
        dec_d = '0;
        if (req_valid) begin
            dec_d.valid = 1'b1;
            dec_d.gp    = seg_viol || gate_viol || (kind == GK_BAD);
            if (!dec_d.gp) begin
                dec_d.clr_if    = (kind == GK_INTR);
                dec_d.task_gate = (kind == GK_TASK);
                dec_d.stk_sw    = ring_change;
                dec_d.err_push  = err_hit;
                dec_d.ret_next  = (evt_class == EVT_TRAP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign gp_fault   = dec_q.gp;
    assign clr_if     = dec_q.clr_if;
    assign stk_switch = dec_q.stk_sw;
    assign err_push   = dec_q.err_push;
    assign ret_next   = dec_q.ret_next;
    assign task_gate  = dec_q.task_gate;

    a_r2_seg_priv: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (cs_sel[1:0] < seg_dpl) |=> dec_valid && gp_fault);

    a_r3_soft_gate: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && soft_evt && (gate_dpl < cs_sel[1:0]) |=> gp_fault);

    a_r3_hw_skip: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !soft_evt && (cs_sel[1:0] >= seg_dpl) && (gate_type == 4'hE)
        |=> !gp_fault && clr_if);

    a_r6_stack: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (cs_sel[1:0] > seg_dpl) && !soft_evt && (gate_type == 4'hF)
        |=> stk_switch);

    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dec_valid);

    a_r10_gp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> !clr_if && !stk_switch && !err_push && !ret_next && !task_gate);

    a_r5_task_no_if: assert property (@(posedge clk) disable iff (!rst_n)
        task_gate |-> !clr_if && dec_valid);
endmodule

// File: tb/tb_gate_priv_checker.sv
`timescale 1ns/1ps
module tb_gate_priv_checker;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [7:0] vector;
    logic       soft_evt;
    logic [15:0] cs_sel;
    logic [3:0] gate_type;
    logic [1:0] gate_dpl, seg_dpl, evt_class;
    logic dec_valid, gp_fault, clr_if, stk_switch, err_push, ret_next, task_gate;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gate_priv_checker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vector(vector),
        .soft_evt(soft_evt), .cs_sel(cs_sel), .gate_type(gate_type),
        .gate_dpl(gate_dpl), .seg_dpl(seg_dpl), .evt_class(evt_class),
        .dec_valid(dec_valid), .gp_fault(gp_fault), .clr_if(clr_if),
        .stk_switch(stk_switch), .err_push(err_push), .ret_next(ret_next),
        .task_gate(task_gate)
    );

    // bundle order: valid gp clr_if stk err ret task
    function automatic logic [6:0] outs();
        return {dec_valid, gp_fault, clr_if, stk_switch, err_push, ret_next, task_gate};
    endfunction

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Present one request at a falling edge; return with the verdict visible.
    task automatic fire(input logic [7:0] v, input logic s, input logic [15:0] cs,
                        input logic [3:0] gt, input logic [1:0] gd,
                        input logic [1:0] sd, input logic [1:0] cl);
        @(negedge clk);
        vector = v; soft_evt = s; cs_sel = cs; gate_type = gt;
        gate_dpl = gd; seg_dpl = sd; evt_class = cl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 reset state", outs(), 7'b0);
    endtask

    task automatic t_kernel_irq();
        fire(8'd32, 0, 16'h0010, 4'hE, 2'd0, 2'd0, 2'b01);
        check("R4 kernel interrupt gate", outs(), 7'b1010010);
        @(negedge clk);
        check("R9 valid is one pulse", outs(), 7'b0);
    endtask

    task automatic t_user_syscall();
        fire(8'd128, 1, 16'h0023, 4'hF, 2'd3, 2'd0, 2'b01);
        check("R3 user soft trap gate dpl3", outs(), 7'b1001010);
    endtask

    task automatic t_soft_blocked();
        fire(8'd128, 1, 16'h0023, 4'hF, 2'd0, 2'd0, 2'b01);
        check("R3 soft blocked by gate dpl0 (R10 quiet)", outs(), 7'b1100000);
    endtask

    task automatic t_hw_skip();
        fire(8'd33, 0, 16'h0023, 4'hE, 2'd0, 2'd0, 2'b01);
        check("R3 hardware skips gate check, R6 switch", outs(), 7'b1011010);
    endtask

    task automatic t_seg_viol();
        fire(8'd40, 0, 16'h0010, 4'hE, 2'd0, 2'd3, 2'b01);
        check("R2 cpl below segment dpl", outs(), 7'b1100000);
    endtask

    task automatic t_cpl_bits();
        fire(8'd40, 0, 16'hFFF0, 4'hE, 2'd0, 2'd0, 2'b01);
        check("R1 upper selector bits ignored", outs(), 7'b1010010);
        fire(8'd40, 0, 16'h0002, 4'hF, 2'd0, 2'd2, 2'b00);
        check("R1 cpl 2 equals segment dpl 2", outs(), 7'b1000000);
    endtask

    task automatic t_errcodes();
        fire(8'd14, 0, 16'h0023, 4'hE, 2'd0, 2'd0, 2'b00);
        check("R8 vector 14 fault pushes code, R7 current insn", outs(), 7'b1011100);
        fire(8'd14, 1, 16'h0023, 4'hF, 2'd3, 2'd0, 2'b00);
        check("R8 soft vector 14 no code", outs(), 7'b1001000);
        fire(8'd17, 0, 16'h0000, 4'hF, 2'd0, 2'd0, 2'b00);
        check("R8 vector 17 pushes code", outs(), 7'b1000100);
        fire(8'd9, 0, 16'h0000, 4'hF, 2'd0, 2'd0, 2'b00);
        check("R8 vector 9 no code", outs(), 7'b1000000);
        fire(8'd10, 0, 16'h0000, 4'hF, 2'd0, 2'd0, 2'b00);
        check("R8 vector 10 pushes code", outs(), 7'b1000100);
        fire(8'd13, 0, 16'h0000, 4'hF, 2'd0, 2'd0, 2'b00);
        check("R8 vector 13 pushes code", outs(), 7'b1000100);
        fire(8'd7, 0, 16'h0000, 4'hF, 2'd0, 2'd0, 2'b01);
        check("R7 trap on vector 7 saves next", outs(), 7'b1000010);
    endtask

    task automatic t_task_gate();
        fire(8'd8, 0, 16'h0000, 4'h5, 2'd0, 2'd0, 2'b10);
        check("R5 task gate abort, R7 abort no next", outs(), 7'b1000101);
    endtask

    task automatic t_types();
        fire(8'd50, 0, 16'h0000, 4'hC, 2'd0, 2'd0, 2'b01);
        check("R5 illegal type faults", outs(), 7'b1100000);
        fire(8'd50, 0, 16'h0000, 4'h6, 2'd0, 2'd0, 2'b01);
        check("R4 type 6 clears IF", outs(), 7'b1010010);
        fire(8'd50, 0, 16'h0000, 4'h7, 2'd0, 2'd0, 2'b01);
        check("R4 type 7 keeps IF", outs(), 7'b1000010);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; vector = '0; soft_evt = 1'b0;
        cs_sel = '0; gate_type = '0; gate_dpl = '0; seg_dpl = '0; evt_class = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_kernel_irq();
        t_user_syscall();
        t_soft_blocked();
        t_hw_skip();
        t_seg_viol();
        t_cpl_bits();
        t_errcodes();
        t_task_gate();
        t_types();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule